// File: doc/BRIEF.md
# Signed Power-of-Two Divide Unit

This block shifts a 32-bit two's-complement operand right by an immediate amount from 0 to 31. The vacated upper positions take copies of the sign bit, and the bits that fall off the low end are discarded. The unit also produces a carry flag. The carry is 1 only when the operand is negative and at least one discarded bit was a 1. In other words, the carry marks a negative shift whose floor result differs from the exact quotient.

In divide mode the unit takes a second cycle and adds the carry to the shifted value. The result is then the operand divided by 2^n, rounded toward zero, instead of the floor value a plain shift gives. When the record input is set, the unit also writes a 4-bit condition field from the final result. That field holds less-than, greater-than, equal and a copied summary-overflow bit.

Each operation starts with a one-cycle valid strobe. It ends with a one-cycle done strobe that marks the outputs as valid.

Top module: `sra_div_unit`

## Requirements
- R1: With divide mode off, out_result equals in_operand shifted right by in_shamt (0 to 31), with vacated upper bits filled with in_operand[31].
- R2: out_carry is 1 exactly when in_operand[31] is 1 and at least one bit among the in_shamt discarded low bits is 1; otherwise it is 0.
- R3: A shift amount of 0 returns the operand unchanged and clears out_carry, in either mode.
- R4: With divide mode on, out_result equals the signed operand divided by 2^in_shamt, rounded toward zero, and out_carry still reports the shift's carry.
- R5: When the record input is set, out_cond is written as {LT, GT, EQ, SO}. Bit 3 is set for a negative result, bit 2 for a positive nonzero result and bit 1 for a zero result, and bit 0 copies in_so.
- R6: When the record input is clear, out_cond keeps its previous value.
- R7: In divide mode, the condition bits describe the final result after the carry has been added.
- R8: A plain shift raises out_done for one cycle right after the clock edge that accepts it. A divide raises out_done one cycle later than that. out_done is low in the cycle after each pulse unless a new operation completes.
- R9: A valid strobe that arrives while a divide is between its two cycles is ignored and changes no output.
- R10: A synchronous active-high reset clears out_result, out_carry, out_cond and out_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Start strobe for one operation |
| in_operand | input | 32 | Signed operand |
| in_shamt | input | 5 | Immediate shift amount |
| in_record | input | 1 | Update the condition field |
| in_divide | input | 1 | Add carry back (truncating divide) |
| in_so | input | 1 | Incoming summary-overflow bit |
| out_result | output | 32 | Shifted or divided result |
| out_carry | output | 1 | Lost-bits carry |
| out_cond | output | 4 | {LT, GT, EQ, SO} |
| out_done | output | 1 | Outputs valid, one-cycle pulse |

## Verification
A fault in the shifter stages or in the lost-bits mask shows up at the next done pulse. It appears as a wrong result for one particular shift amount, or as a carry on an exactly divisible negative operand. A stuck pending-divide state shows within one cycle, either as a missing done pulse or as a second operation that gets accepted when it should not. A wrong choice of source for the condition field appears only when the record input is set, and only in divide mode. The clearest case is a negative operand that rounds to zero.

// File: rtl/sra_div_pkg.sv
package sra_div_pkg;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ADD  = 1'b1
  } div_state_t;

endpackage

// File: rtl/sra_log_shifter.sv
module sra_log_shifter #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHW = 5
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] shamt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stage [SHW+1];
  assign stage[0] = din;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int unsigned STEP = 2 ** i;
    assign stage[i+1] = shamt[i]
      ? {{STEP{din[W-1]}}, stage[i][W-1:STEP]}
      : stage[i];
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/sra_lost_bits.sv
module sra_lost_bits #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHW = 5
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] shamt,
  output logic           carry
);
  logic [W-1:0] low_mask;
  assign low_mask = ~({W{1'b1}} << shamt);
  assign carry    = din[W-1] & (|(din & low_mask));
endmodule

// File: rtl/sra_cond_gen.sv
module sra_cond_gen
  import sra_div_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] value,
  input  logic         so_in,
  output cond_t        cond
);
  logic is_zero;
  assign is_zero = (value == '0);
  assign cond.lt = value[W-1];
  assign cond.gt = !value[W-1] && !is_zero;
  assign cond.eq = is_zero;
  assign cond.so = so_in;
endmodule

// File: rtl/sra_div_unit.sv
module sra_div_unit
  import sra_div_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [SH_W-1:0]   in_shamt,
  input  logic              in_record,
  input  logic              in_divide,
  input  logic              in_so,
  output logic [DATA_W-1:0] out_result,
  output logic              out_carry,
  output logic [3:0]        out_cond,
  output logic              out_done
);
  div_state_t        state;
  logic [DATA_W-1:0] shifted;
  logic              shift_carry;
  logic [DATA_W-1:0] hold_val;
  logic              hold_carry;
  logic              hold_rec;
  logic              hold_so;
  logic [DATA_W-1:0] sum_val;
  logic [DATA_W-1:0] cond_src;
  logic              cond_so;
  cond_t             cond_next;

  // Named internal events used by the checker
  logic busy;
  logic accept;
  logic cond_wr;

  assign busy    = (state == ST_ADD);
  assign accept  = in_valid && !busy;
  assign cond_wr = (accept && !in_divide && in_record) || (busy && hold_rec);

  sra_log_shifter #(.W(DATA_W), .SHW(SH_W)) u_shift (
    .din(in_operand), .shamt(in_shamt), .dout(shifted)
  );

  sra_lost_bits #(.W(DATA_W), .SHW(SH_W)) u_lost (
    .din(in_operand), .shamt(in_shamt), .carry(shift_carry)
  );

  assign sum_val  = hold_val + {{(DATA_W-1){1'b0}}, hold_carry};
  assign cond_src = busy ? sum_val : shifted;
  assign cond_so  = busy ? hold_so : in_so;

  sra_cond_gen #(.W(DATA_W)) u_cond (
    .value(cond_src), .so_in(cond_so), .cond(cond_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      out_result <= '0;
      out_carry  <= 1'b0;
      out_cond   <= '0;
      out_done   <= 1'b0;
      hold_val   <= '0;
      hold_carry <= 1'b0;
      hold_rec   <= 1'b0;
      hold_so    <= 1'b0;
    end else begin
      out_done <= 1'b0;
      if (cond_wr) out_cond <= cond_next;
      if (busy) begin
        out_result <= sum_val;
        out_carry  <= hold_carry;
        out_done   <= 1'b1;
        state      <= ST_IDLE;
      end else if (accept) begin
        if (in_divide) begin
          hold_val   <= shifted;
          hold_carry <= shift_carry;
          hold_rec   <= in_record;
          hold_so    <= in_so;
          state      <= ST_ADD;
        end else begin
          out_result <= shifted;
          out_carry  <= shift_carry;
          out_done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sra_div_chk.sv
module sra_div_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SH_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_operand,
  input logic [SH_W-1:0]   in_shamt,
  input logic              in_divide,
  input logic [DATA_W-1:0] out_result,
  input logic              out_carry,
  input logic [3:0]        out_cond,
  input logic              out_done,
  input logic              busy,
  input logic              accept,
  input logic              cond_wr
);
  a_r2_carry_needs_negative: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_divide && !in_operand[DATA_W-1]) |=> !out_carry);

  a_r3_zero_shift_identity: assert property (@(posedge clk) disable iff (rst)
    (accept && !in_divide && in_shamt == '0) |=>
      (out_result == $past(in_operand) && !out_carry));

  a_r5_single_sign_class: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_cond[3:1]));

  a_r6_cond_holds: assert property (@(posedge clk) disable iff (rst)
    !cond_wr |=> $stable(out_cond));

  a_r8_divide_completes: assert property (@(posedge clk) disable iff (rst)
    busy |=> (out_done && !busy));

  a_r8_divide_no_early_done: assert property (@(posedge clk) disable iff (rst)
    (accept && in_divide) |=> (busy && !out_done));

  a_r9_ignore_while_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && in_valid) |-> !accept);
endmodule

bind sra_div_unit sra_div_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
  .in_shamt(in_shamt), .in_divide(in_divide), .out_result(out_result),
  .out_carry(out_carry), .out_cond(out_cond), .out_done(out_done),
  .busy(busy), .accept(accept), .cond_wr(cond_wr)
);

// File: tb/tb_sra_div_unit.sv
module tb_sra_div_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_operand;
  logic [4:0]  in_shamt;
  logic        in_record;
  logic        in_divide;
  logic        in_so;
  logic [31:0] out_result;
  logic        out_carry;
  logic [3:0]  out_cond;
  logic        out_done;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_cond = 4'b0000;

  always #2 clk = ~clk;

  sra_div_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_shamt(in_shamt), .in_record(in_record), .in_divide(in_divide),
    .in_so(in_so), .out_result(out_result), .out_carry(out_carry),
    .out_cond(out_cond), .out_done(out_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_cond(input logic [31:0] v, input logic so);
    return {$signed(v) < 0, $signed(v) > 0, v == 32'd0, so};
  endfunction

  task automatic run_op(input string req, input logic [31:0] op,
                        input logic [4:0] sh, input logic rec,
                        input logic div, input logic so);
    logic [31:0] fl;
    logic        e_c;
    logic [31:0] e_res;
    longint      q;
    fl    = $signed(op) >>> sh;
    e_c   = op[31] && ((fl << sh) != op);
    q     = longint'($signed(op)) / (longint'(1) << sh);
    e_res = div ? q[31:0] : fl;
    if (rec) exp_cond = ref_cond(e_res, so);
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_shamt = sh;
    in_record = rec; in_divide = div; in_so = so;
    @(negedge clk);
    in_valid = 1'b0;
    if (div) begin
      chk(out_done == 1'b0, "R8", "early done", {31'd0, out_done}, 32'd0);
      @(negedge clk);
    end
    chk(out_done == 1'b1, "R8", "done", {31'd0, out_done}, 32'd1);
    chk(out_result == e_res, req, "result", out_result, e_res);
    chk(out_carry == e_c, "R2", "carry", {31'd0, out_carry}, {31'd0, e_c});
    chk(out_cond == exp_cond, rec ? "R5" : "R6", "cond",
        {28'd0, out_cond}, {28'd0, exp_cond});
    @(negedge clk);
    chk(out_done == 1'b0, "R8", "done pulse width", {31'd0, out_done}, 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; in_operand = '0; in_shamt = '0;
    in_record = 1'b0; in_divide = 1'b0; in_so = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_result == 32'd0 && out_carry == 1'b0 && out_cond == 4'd0 && out_done == 1'b0,
        "R10", "reset state", out_result, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_plain_shifts;
    run_op("R1", 32'h1234_5678, 5'd4, 1'b1, 1'b0, 1'b0);
    run_op("R1", 32'h8000_0001, 5'd1, 1'b1, 1'b0, 1'b0);
    run_op("R2", 32'hFFFF_FF00, 5'd8, 1'b1, 1'b0, 1'b1);
    run_op("R1", 32'h8000_0000, 5'd31, 1'b1, 1'b0, 1'b0);
    run_op("R1", 32'h7FFF_FFFF, 5'd31, 1'b1, 1'b0, 1'b0);
    run_op("R2", 32'hF000_0000, 5'd29, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_zero_shift;
    run_op("R3", 32'h8765_4321, 5'd0, 1'b1, 1'b0, 1'b0);
    run_op("R3", 32'hFFFF_FFFF, 5'd0, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_divide;
    run_op("R4", 32'hFFFF_FFF9, 5'd1, 1'b1, 1'b1, 1'b0);
    run_op("R4", 32'd100, 5'd3, 1'b1, 1'b1, 1'b0);
    run_op("R4", 32'h8000_0000, 5'd31, 1'b1, 1'b1, 1'b0);
    // R7: raw shift of -1 is negative, the divided result is zero
    run_op("R7", 32'hFFFF_FFFF, 5'd4, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_record_hold;
    run_op("R5", 32'h0000_0040, 5'd2, 1'b1, 1'b0, 1'b1);
    run_op("R6", 32'h8000_0000, 5'd3, 1'b0, 1'b0, 1'b0);
    run_op("R6", 32'h0000_0000, 5'd3, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_ignore_busy;
    // R9: second strobe arrives while the divide is pending
    @(negedge clk);
    in_valid = 1'b1; in_operand = 32'hFFFF_FFF1; in_shamt = 5'd2;
    in_record = 1'b1; in_divide = 1'b1; in_so = 1'b0;
    exp_cond = 4'b1000;
    @(negedge clk);
    in_operand = 32'h0000_1000; in_shamt = 5'd4; in_divide = 1'b0;
    in_record = 1'b1; in_so = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_done == 1'b1, "R8", "divide done", {31'd0, out_done}, 32'd1);
    chk(out_result == 32'hFFFF_FFFD, "R4", "divide result", out_result, 32'hFFFF_FFFD);
    @(negedge clk);
    chk(out_done == 1'b0, "R9", "ignored strobe done", {31'd0, out_done}, 32'd0);
    chk(out_result == 32'hFFFF_FFFD, "R9", "ignored strobe result", out_result, 32'hFFFF_FFFD);
    chk(out_cond == exp_cond, "R9", "ignored strobe cond", {28'd0, out_cond}, {28'd0, exp_cond});
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(out_result == 32'd0 && out_carry == 1'b0 && out_cond == 4'd0 && out_done == 1'b0,
        "R10", "reset after use", out_result, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_plain_shifts();
    t_zero_shift();
    t_divide();
    t_record_hold();
    t_ignore_busy();
    t_reset_again();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule